// File: doc/BRIEF.md
# Stepped Bidirectional Word Rotation Network

This block rotates a row of N client words around a ring by an arbitrary distance. Each client holds one W-bit word. Wiring a full crossbar for every possible distance would be too costly, so the rotation runs as a series of hops of at most STEP positions, one hop per clock. The words stay in the network's register between hops and are never reloaded. The control always takes the shorter way round the ring: a request to go more than half the ring in one direction is carried out as the complementary distance in the other direction.

The datapath is a set of identical one-bit switch units. Each unit serves STEP neighbouring clients and sees STEP clients on each side. Switch units are chained around the ring, and the chain is repeated once per bit plane.

A caller presents the words, the distance and the direction together with a one-cycle start strobe. It then waits for the single-cycle done pulse and reads the rotated words, which stay on the output until the next accepted start.

Top module: `rot_net`

## Requirements
- R1: Word i occupies bits [i*W +: W] of the data buses. With dirLeft=1 and distance k, the result satisfies out[i] = in[(i+k) mod N]. With dirLeft=0, the result satisfies out[i] = in[(i-k) mod N]. Words leaving one end of the ring enter at the other end.
- R2: A request with k > N/2 is executed as a move of N-k positions in the opposite direction. The final words are the same as for the requested rotation, and the latency is set by N-k.
- R3: Let k' be the executed distance: k for k <= N/2, and N-k otherwise. If start is sampled at clock edge E, done is high in the cycle that follows edge E+ceil(k'/STEP), and the output holds the result in that cycle. For k = N/2 this latency is the worst case, ceil(N/2/STEP).
- R4: When k' is not a multiple of STEP, the last hop moves k' mod STEP positions, and every earlier hop moves STEP positions.
- R5: When k = 0, done is high in the cycle after the start edge, and the output equals the input words.
- R6: Done lasts exactly one cycle when no new start follows it.
- R7: A start that arrives while a rotation is in progress is ignored. The running rotation's result and its done timing do not change, and no extra done pulse appears.
- R8: After done, the output keeps the result until the next accepted start. Changes on dataIn, amount and dirLeft in that interval have no effect.
- R9: After reset, done is 0 and every output bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| dirLeft | input | 1 | 1 rotates toward lower indices, 0 toward higher |
| amount | input | $clog2(N) | Rotation distance k, 0 to N-1 |
| dataIn | input | N*W | Input words, word i at [i*W +: W] |
| dataOut | output | N*W | Rotated words, held between rotations |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
Several internal faults produce visible port symptoms:
- A wrong hop size or a remaining count that is decremented wrongly moves done by one or more cycles from ceil(k'/STEP). It also leaves words displaced from their expected positions, and both show in the very cycle done is sampled.
- A wrong shorter-path decision gives an inverted rotation, or the long latency, for every k above N/2.
- A broken wrap between the switch units corrupts only the words that cross the ring ends.
- A missing busy guard shows up as a changed result or a second done pulse after a stray start.

A sweep of every distance in both directions exposes each of these faults within a few cycles of the rotation concerned.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic left;
  } rotCtrlT;
endpackage

// File: rtl/rot_bsu.sv
module rot_bsu #(
  parameter int STEP = 8,
  localparam int HW = $clog2(STEP + 1),
  localparam int IW = $clog2(3 * STEP)
) (
  input  logic [3*STEP-1:0] win,
  input  logic [HW-1:0]     hop,
  input  logic              left,
  output logic [STEP-1:0]   out
);
  logic [IW-1:0] idx [STEP];

  always_comb begin
    for (int j = 0; j < STEP; j++) begin
      if (left) idx[j] = IW'(STEP + j) + IW'(hop);
      else      idx[j] = IW'(STEP + j) - IW'(hop);
      out[j] = win[idx[j]];
    end
  end
endmodule

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_pkg::*;
#(
  parameter int N    = 256,
  parameter int STEP = 8,
  localparam int KW = $clog2(N),
  localparam int HW = $clog2(STEP + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          dirLeft,
  input  logic [KW-1:0] amount,
  output rotCtrlT       ctrl,
  output logic [HW-1:0] hop,
  output logic          done
);
  localparam logic [KW:0]   HALF  = (KW + 1)'(N / 2);
  localparam logic [KW:0]   FULL  = (KW + 1)'(N);
  localparam logic [KW-1:0] STEPK = KW'(STEP);

  logic [KW:0]   kExt, distFull;
  logic          effLeft, leftQ, busy;
  logic [KW-1:0] remaining;

  always_comb begin
    kExt = {1'b0, amount};
    if (kExt > HALF) begin
      distFull = FULL - kExt;
      effLeft  = ~dirLeft;
    end else begin
      distFull = kExt;
      effLeft  = dirLeft;
    end
  end

  assign busy       = remaining != '0;
  assign hop        = (remaining >= STEPK) ? HW'(STEP) : HW'(remaining);
  assign ctrl.load  = start && !busy;
  assign ctrl.shift = busy;
  assign ctrl.left  = leftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      leftQ     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        remaining <= distFull[KW-1:0];
        leftQ     <= effLeft;
        done      <= distFull == '0;
      end else if (busy) begin
        remaining <= remaining - KW'(hop);
        if (remaining <= STEPK) done <= 1'b1;
      end
    end
  end

  // R4
  hop_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shift |-> (hop != '0 && hop <= HW'(STEP)));
  // R2
  short_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    remaining <= HALF[KW-1:0]);
  // R3
  progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> remaining < $past(remaining));
  // R7
  busy_hold_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(leftQ));
endmodule

// File: rtl/rot_path.sv
module rot_path
  import rot_pkg::*;
#(
  parameter int N    = 256,
  parameter int W    = 8,
  parameter int STEP = 8,
  localparam int HW     = $clog2(STEP + 1),
  localparam int GROUPS = N / STEP
) (
  input  logic           clk,
  input  logic           rstN,
  input  rotCtrlT        ctrl,
  input  logic [HW-1:0]  hop,
  input  logic [N*W-1:0] dataIn,
  output logic [N*W-1:0] dataOut
);
  logic [N*W-1:0] dataReg, nextReg;
  logic [N*W-1:0] bsuOut;

  for (genvar b = 0; b < W; b++) begin : g_plane
    for (genvar g = 0; g < GROUPS; g++) begin : g_unit
      logic [3*STEP-1:0] win;
      for (genvar m = 0; m < 3 * STEP; m++) begin : g_win
        assign win[m] = dataReg[((g * STEP + N - STEP + m) % N) * W + b];
      end
      rot_bsu #(.STEP(STEP)) i_bsu (
        .win (win),
        .hop (hop),
        .left(ctrl.left),
        .out (bsuOut[b*N + g*STEP +: STEP])
      );
    end
    for (genvar i = 0; i < N; i++) begin : g_back
      assign nextReg[i*W + b] = bsuOut[b*N + i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           dataReg <= '0;
    else if (ctrl.load)  dataReg <= dataIn;
    else if (ctrl.shift) dataReg <= nextReg;
  end

  assign dataOut = dataReg;

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.load || ctrl.shift) |=> $stable(dataOut));
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.load, ctrl.shift}));
endmodule

// File: rtl/rot_net.sv
module rot_net
  import rot_pkg::*;
#(
  parameter int N    = 256,
  parameter int W    = 8,
  parameter int STEP = 8,
  localparam int KW = $clog2(N),
  localparam int HW = $clog2(STEP + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           dirLeft,
  input  logic [KW-1:0]  amount,
  input  logic [N*W-1:0] dataIn,
  output logic [N*W-1:0] dataOut,
  output logic           done
);
  rotCtrlT       ctrl;
  logic [HW-1:0] hop;

  initial begin
    // R1
    geom_chk: assert (N % STEP == 0 && STEP < N && N >= 2);
  end

  rot_ctrl #(.N(N), .STEP(STEP)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dirLeft(dirLeft),
    .amount(amount), .ctrl(ctrl), .hop(hop), .done(done)
  );

  rot_path #(.N(N), .W(W), .STEP(STEP)) i_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .hop(hop),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/test_rot_net.sv
module test_rot_net;
  localparam int N = 16, W = 5, STEP = 4, KW = $clog2(N);

  logic clk = 0, rstN = 0, start = 0, dirLeft = 0;
  logic [KW-1:0] amount = '0;
  logic [N*W-1:0] dataIn = '0, dataOut, expWords;
  logic done;
  int vectors = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rot_net #(.N(N), .W(W), .STEP(STEP)) i_rot_net (
    .clk(clk), .rstN(rstN), .start(start), .dirLeft(dirLeft),
    .amount(amount), .dataIn(dataIn), .dataOut(dataOut), .done(done)
  );

  function automatic logic [N*W-1:0] mkWords(int pat);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'((i * (2 * pat + 1) + 7 * pat) % 32);
    return v;
  endfunction

  function automatic logic [N*W-1:0] rotRef(logic [N*W-1:0] v, bit lft, int k);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++)
      r[i*W +: W] = lft ? v[((i + k) % N)*W +: W] : v[((i - k + N) % N)*W +: W];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRot(bit lft, int k, int pat, bit stray);
    int kp, expLat, lat;
    kp = (k > N / 2) ? N - k : k;
    expLat = (kp + STEP - 1) / STEP;
    expWords = rotRef(mkWords(pat), lft, k);
    @(negedge clk);
    start = 1; dirLeft = lft; amount = KW'(k); dataIn = mkWords(pat);
    @(posedge clk);
    @(negedge clk);
    start = 0;
    lat = 0;
    while (!done && lat < 40) begin
      if (stray && lat == 0) begin
        start = 1; dirLeft = ~lft; amount = KW'(3); dataIn = ~mkWords(pat);
      end
      @(posedge clk);
      @(negedge clk);
      start = 0;
      lat++;
    end
    // R1 R2 R4: words after the rotation
    check(dataOut == expWords, "R1/R2/R4 data", dataOut, expWords);
    // R3 R5 R7: done latency
    check(done && lat == expLat, stray ? "R7 latency" : (k == 0 ? "R5 latency" : "R3 latency"),
          (N*W)'(lat), (N*W)'(expLat));
    dataIn = mkWords(pat + 5); amount = KW'(5); dirLeft = ~lft;
    @(posedge clk);
    @(negedge clk);
    // R6 single pulse
    check(!done, "R6 done drop", (N*W)'(done), '0);
    // R8 output held
    check(dataOut == expWords, "R8 hold", dataOut, expWords);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset values
    check(dataOut == '0 && !done, "R9 reset", dataOut, '0);
    rstN = 1;
    for (int pat = 0; pat < 3; pat++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < N; k++)
          doRot(d[0], k, pat, (k % 3 == 1));
    // R3 worst case and R5 zero distance once more explicitly
    doRot(1'b0, N / 2, 4, 1'b0);
    doRot(1'b1, 0, 6, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule